// File: doc/BRIEF.md
# Two-Bank Interleaved Request Dispatcher

This block accepts one stream of read and write requests from a single processor-side port and steers each request to one of two cache banks that run side by side. The steering key is the parity of the 256-byte line number, so consecutive lines alternate between the banks. Each bank keeps its own short queue, has its own service time set from a port, and owns a small word-addressed backing store.

Completed requests come back on one shared response port that carries the original request ID. A slow bank does not hold up a fast one, so a later request sent to an idle bank can return before an earlier request that is still waiting in a busy bank. Within one bank, order is kept. When both banks finish together, a round-robin arbiter picks which one goes first. The bank that loses keeps its result until the port takes it.

Top module: `bdisp_top`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1 for any address.
- R2: Address bit 8 selects the bank: a line with bit 8 clear goes to bank 0 and a line with bit 8 set goes to bank 1. `rsp_bank` reports the bank that serves the response.
- R3: Each bank queues up to 4 requests. `req_ready` is low only when the queue of the bank selected by the present `req_addr` is full. A request aimed at the other bank still sees `req_ready` high.
- R4: Take a bank that is idle, with its result slot free and the response port ready. A request accepted at clock edge E makes `rsp_valid` high after edge E+L+2, where L is that bank's service-cycle input.
- R5: Requests to one bank complete strictly in the order that bank accepted them.
- R6: The banks are independent. When bank 0 is slow and bank 1 is fast, later requests to bank 1 complete before earlier requests to bank 0.
- R7: Reads reorder across banks in the same way as writes. A read returns the word most recently written to the same address in issue order. `rsp_write` echoes the request type, and `rsp_rdata` is 0 for writes.
- R8: When both banks hold a result and the port is ready in the same cycle, the grant goes to the bank that was not granted in the last accepted response.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response does not change. This holds even if the other bank finishes meanwhile.
- R10: The backing-store word is selected by address bits [7:2] and bit 9. Bits [1:0] and bits 10 and up have no effect, so addresses 0x000 and 0x400 name the same word, while 0x000 and 0x200 name different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Selected bank queue can take the request |
| req_id | input | 8 | Request tag |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| svc_cycles_b0 | input | 8 | Service cycle count of bank 0 |
| svc_cycles_b1 | input | 8 | Service cycle count of bank 1 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_id | output | 8 | Tag of completed request |
| rsp_write | output | 1 | Completed request was a write |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| rsp_bank | output | 1 | Bank that served the response |

## Verification
The bench holds bank 0 busy with a long service time while it sends mixed reads and writes to both banks. A dispatcher that serialised the banks, or that steered on the wrong address bit, would then return IDs in issue order or report the wrong bank. A held response with a second bank finishing behind it shows whether the arbiter switches the grant under a stall. Two simultaneous-finish rounds with opposite previous grants expose a fixed-priority arbiter. A full bank-0 queue with a bank-1 address on the port catches backpressure that is applied globally, and aliased and non-aliased addresses expose a store index that uses the wrong bits.

// File: rtl/bdisp_pkg.sv
package bdisp_pkg;
  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_BUSY = 2'd1,
    BK_DONE = 2'd2
  } bk_state_e;
endpackage

// File: rtl/bdisp_fifo.sv
module bdisp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CNT_W-1:0] count, count_n;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = store[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (push) wr_ptr_n = wr_ptr + PTR_W'(1);
    if (pop)  rd_ptr_n = rd_ptr + PTR_W'(1);
    if (push && !pop) count_n = count + CNT_W'(1);
    else if (pop && !push) count_n = count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R5
endmodule

// File: rtl/bdisp_bank.sv
module bdisp_bank
  import bdisp_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7,
  parameter int DEPTH  = 4,
  parameter int LAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic              push_wr,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic [DATA_W-1:0] push_wdata,
  input  logic [LAT_W-1:0]  lat,
  input  logic              take,
  output logic              full,
  output logic              res_vld,
  output logic [ID_W-1:0]   res_id,
  output logic              res_wr,
  output logic [DATA_W-1:0] res_data
);
  localparam int ENT_W = ID_W + 1 + IDX_W + DATA_W;
  localparam int WORDS = 1 << IDX_W;

  logic [ENT_W-1:0]  q_in, q_out;
  logic              q_empty, pop;
  logic [ID_W-1:0]   hd_id;
  logic              hd_wr;
  logic [IDX_W-1:0]  hd_idx;
  logic [DATA_W-1:0] hd_wdata;

  bk_state_e         state, state_n;
  logic [LAT_W-1:0]  cnt, cnt_n;
  logic              cap;
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rd_word;

  assign q_in = {push_id, push_wr, push_idx, push_wdata};
  assign {hd_id, hd_wr, hd_idx, hd_wdata} = q_out;

  bdisp_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .din(q_in), .pop(pop),
    .dout(q_out), .full(full), .empty(q_empty)
  );

  assign rd_word = mem[hd_idx];

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    cap     = 1'b0;
    unique case (state)
      BK_IDLE: if (!q_empty) begin
        state_n = BK_BUSY;
        cnt_n   = lat;
      end
      BK_BUSY: if (cnt == '0) begin
        state_n = BK_DONE;
        cap     = 1'b1;
      end else begin
        cnt_n = cnt - LAT_W'(1);
      end
      BK_DONE: if (take) state_n = BK_IDLE;
      default: state_n = BK_IDLE;
    endcase
  end
  assign pop = cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BK_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (cap && hd_wr) mem[hd_idx] <= hd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_id   <= '0;
      res_wr   <= 1'b0;
      res_data <= '0;
    end else if (cap) begin
      res_id   <= hd_id;
      res_wr   <= hd_wr;
      res_data <= hd_wr ? '0 : rd_word;
    end
  end

  assign res_vld = (state == BK_DONE);

  AST_BUSY_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BK_BUSY) |-> !q_empty); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !take) |=> (res_vld && $stable(res_id) && $stable(res_data))); // R9
endmodule

// File: rtl/bdisp_rsp_arb.sv
module bdisp_rsp_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] vld,
  input  logic       out_ready,
  output logic       out_valid,
  output logic       sel,
  output logic [1:0] gnt
);
  logic pri, pri_n;

  always_comb begin
    sel       = vld[pri] ? pri : ~pri;
    out_valid = |vld;
    gnt       = '0;
    if (out_valid && out_ready) gnt[sel] = 1'b1;
    pri_n = pri;
    if (out_valid && out_ready) pri_n = ~sel;
    else if (out_valid)         pri_n = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pri <= 1'b0;
    else        pri <= pri_n;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8
  AST_LOSER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld && out_ready) |=> (out_valid && sel != $past(sel))); // R8
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && sel == $past(sel))); // R9
endmodule

// File: rtl/bdisp_top.sv
module bdisp_top #(
  parameter int ID_W     = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LAT_W    = 8,
  parameter int DEPTH    = 4,
  parameter int LINE_LSB = 8,
  parameter int IDX_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LAT_W-1:0]  svc_cycles_b0,
  input  logic [LAT_W-1:0]  svc_cycles_b1,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_id,
  output logic              rsp_write,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_bank
);
  localparam int NB      = 2;
  localparam int WORD_B  = LINE_LSB - 2;
  localparam int HI_B    = IDX_W - WORD_B;
  localparam int HI_LSB  = LINE_LSB + 1;
  localparam int TOP_LSB = HI_LSB + HI_B;

  logic              bank_sel, fire;
  logic [IDX_W-1:0]  word_idx;
  logic [NB-1:0]     b_full, b_vld, b_gnt, b_push;
  logic [ID_W-1:0]   b_id   [NB];
  logic              b_wr   [NB];
  logic [DATA_W-1:0] b_data [NB];
  logic [LAT_W-1:0]  b_lat  [NB];
  logic              arb_sel;
  logic              unused_addr_bits;

  assign bank_sel  = req_addr[LINE_LSB];
  assign word_idx  = {req_addr[HI_LSB +: HI_B], req_addr[LINE_LSB-1:2]};
  assign unused_addr_bits = ^{req_addr[1:0], req_addr[ADDR_W-1:TOP_LSB]};
  assign req_ready = ~b_full[bank_sel];
  assign fire      = req_valid && req_ready;
  assign b_lat[0]  = svc_cycles_b0;
  assign b_lat[1]  = svc_cycles_b1;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign b_push[g] = fire && (bank_sel == 1'(g));
    bdisp_bank #(
      .ID_W(ID_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .LAT_W(LAT_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .push(b_push[g]), .push_id(req_id), .push_wr(req_write),
      .push_idx(word_idx), .push_wdata(req_wdata),
      .lat(b_lat[g]), .take(b_gnt[g]), .full(b_full[g]),
      .res_vld(b_vld[g]), .res_id(b_id[g]), .res_wr(b_wr[g]), .res_data(b_data[g])
    );
  end

  bdisp_rsp_arb u_arb (
    .clk(clk), .rst_n(rst_n), .vld(b_vld), .out_ready(rsp_ready),
    .out_valid(rsp_valid), .sel(arb_sel), .gnt(b_gnt)
  );

  assign rsp_id    = b_id[arb_sel];
  assign rsp_write = b_wr[arb_sel];
  assign rsp_rdata = b_data[arb_sel];
  assign rsp_bank  = arb_sel;

  AST_STEER_BANK1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bank_sel) |-> !b_push[0]); // R2
  AST_STALL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) && $stable(rsp_bank))); // R9
endmodule

// File: tb/sim_bdisp_top.sv
module sim_bdisp_top;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_id;
  logic [31:0] req_addr, req_wdata;
  logic [7:0]  lat0, lat1;
  logic        rsp_valid, rsp_ready, rsp_write, rsp_bank;
  logic [7:0]  rsp_id;
  logic [31:0] rsp_rdata;

  int n_chk, n_fail, cycles;
  bit finished;

  logic [7:0]  log_id   [64];
  logic        log_bank [64];
  logic [31:0] log_data [64];
  int          log_n;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic [7:0]  pos;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 32'h0000_0000, 32'hA0A0_0001, 32'h0, 8'd4},
    '{1'b1, 32'h0000_0100, 32'hB0B0_0002, 32'h0, 8'd0},
    '{1'b1, 32'h0000_0104, 32'hC0C0_0003, 32'h0, 8'd1},
    '{1'b0, 32'h0000_0000, 32'h0, 32'hA0A0_0001, 8'd5},
    '{1'b0, 32'h0000_0100, 32'h0, 32'hB0B0_0002, 8'd2},
    '{1'b1, 32'h0000_0000, 32'hD0D0_0004, 32'h0, 8'd6},
    '{1'b0, 32'h0000_0000, 32'h0, 32'hD0D0_0004, 8'd7},
    '{1'b0, 32'h0000_0104, 32'h0, 32'hC0C0_0003, 8'd3}
  };

  bdisp_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .svc_cycles_b0(lat0), .svc_cycles_b1(lat1),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
    .rsp_write(rsp_write), .rsp_rdata(rsp_rdata), .rsp_bank(rsp_bank)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready && log_n < 64) begin
      log_id[log_n]   = rsp_id;
      log_bank[log_n] = rsp_bank;
      log_data[log_n] = rsp_rdata;
      log_n = log_n + 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    finished = 1'b1;
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles == 150000 && !finished) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] id, input logic wr, input logic [31:0] addr, input logic [31:0] data);
    req_valid = 1'b1; req_id = id; req_write = wr; req_addr = addr; req_wdata = data;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_log(input int target);
    while (log_n < target) @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int base, n, first;
    n_chk = 0; n_fail = 0; cycles = 0; log_n = 0; finished = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; lat0 = 8'd0; lat1 = 8'd0; rsp_ready = 1'b1;
    idle(3);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(2);

    // Table walk: bank 0 slow, bank 1 fast (R2 R5 R6 R7)
    lat0 = 8'd20; lat1 = 8'd1;
    base = log_n;
    for (int i = 0; i < 8; i++) send(8'(i), VEC[i].wr, VEC[i].addr, VEC[i].wdata);
    wait_log(base + 8);
    for (int i = 0; i < 8; i++) begin
      int p;
      p = base + int'(VEC[i].pos);
      chk(log_id[p] == 8'(i), "R6 R5 completion order", 32'(log_id[p]), 32'(i));
      chk(log_bank[p] == VEC[i].addr[8], "R2 bank", 32'(log_bank[p]), 32'(VEC[i].addr[8]));
      if (!VEC[i].wr)
        chk(log_data[p] == VEC[i].exp_rd, "R7 read data", log_data[p], VEC[i].exp_rd);
      else
        chk(log_data[p] == 32'd0, "R7 write rdata zero", log_data[p], 32'd0);
    end

    // R4 latency from acceptance to response
    lat1 = 8'd3;
    idle(4);
    send(8'h40, 1'b1, 32'h0000_0108, 32'h1);
    n = 0;
    while (!rsp_valid && n < 40) begin
      @(posedge clk); n = n + 1; #1;
    end
    chk(n == 5, "R4 latency edges", 32'(n), 32'd5);
    idle(4);

    // R8 round robin: previous response came from bank 1
    lat0 = 8'd1; lat1 = 8'd0;
    base = log_n;
    send(8'h50, 1'b1, 32'h0000_0008, 32'h5);
    send(8'h51, 1'b1, 32'h0000_0108, 32'h6);
    wait_log(base + 2);
    chk(log_bank[base] == 1'b0, "R8 first grant after bank1", 32'(log_bank[base]), 32'd0);
    chk(log_id[base + 1] == 8'h51, "R8 second grant", 32'(log_id[base + 1]), 32'h51);
    send(8'h52, 1'b1, 32'h0000_000C, 32'h7);
    wait_log(base + 3);
    idle(2);
    base = log_n;
    send(8'h53, 1'b1, 32'h0000_0010, 32'h8);
    send(8'h54, 1'b1, 32'h0000_0110, 32'h9);
    wait_log(base + 2);
    first = int'(log_bank[base]);
    chk(first == 1, "R8 first grant after bank0", 32'(first), 32'd1);
    chk(log_id[base] == 8'h54, "R8 winner id", 32'(log_id[base]), 32'h54);

    // R9 stall keeps response stable while other bank finishes
    lat0 = 8'd0; lat1 = 8'd0;
    idle(2);
    rsp_ready = 1'b0;
    base = log_n;
    send(8'h60, 1'b0, 32'h0000_0008, 32'h0);
    idle(4);
    send(8'h61, 1'b1, 32'h0000_0114, 32'hE);
    idle(5);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R9 valid held", 32'(rsp_valid), 32'd1);
    chk(rsp_id == 8'h60, "R9 id held", 32'(rsp_id), 32'h60);
    chk(rsp_rdata == 32'h5, "R9 data held", rsp_rdata, 32'h5);
    @(posedge clk); #1 rsp_ready = 1'b1;
    wait_log(base + 2);
    chk(log_id[base + 1] == 8'h61, "R9 second after release", 32'(log_id[base + 1]), 32'h61);

    // R3 per-bank backpressure
    lat0 = 8'd60;
    idle(2);
    base = log_n;
    for (int i = 0; i < 4; i++) send(8'(8'h70 + i), 1'b1, 32'h0000_0020, 32'(i));
    idle(2);
    req_addr = 32'h0000_0030;
    @(negedge clk);
    chk(req_ready == 1'b0, "R3 bank0 full", 32'(req_ready), 32'd0);
    req_addr = 32'h0000_0130;
    @(negedge clk);
    chk(req_ready == 1'b1, "R3 bank1 free", 32'(req_ready), 32'd1);
    wait_log(base + 4);
    lat0 = 8'd0;

    // R10 store index bits
    idle(2);
    base = log_n;
    send(8'h80, 1'b1, 32'h0000_0040, 32'h1111_0000);
    send(8'h81, 1'b1, 32'h0000_0240, 32'h2222_0000);
    send(8'h82, 1'b0, 32'h0000_0443, 32'h0);
    send(8'h83, 1'b0, 32'hF000_0640, 32'h0);
    wait_log(base + 4);
    chk(log_data[base + 2] == 32'h1111_0000, "R10 alias above bit 9", log_data[base + 2], 32'h1111_0000);
    chk(log_data[base + 3] == 32'h2222_0000, "R10 bit 9 separates", log_data[base + 3], 32'h2222_0000);

    idle(4);
    summary();
  end
endmodule